// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog peripheral driven by a slow tick of about 32 kHz. The tick arrives as a one-cycle enable on the system clock. The tick first goes through a power-of-two prescaler. Each prescaler output step then decrements a count that is loaded from a 16-bit timeout register. When the count runs out, the first stage ends and takes its programmed action. The count then reloads and runs a second stage, which has its own action. At the end of the second stage the overflow flag is set, and counting starts again from stage one.

Software keeps the watchdog from expiring by writing the timeout register, which is the kick. Each stage can request nothing, an interrupt, a system-management interrupt or a system reset. Sticky status flags record every action that has fired, and all of them are cleared through the overflow bit. A configuration bit gates the tick off.

Registers are reached over a plain halfword register bus:
- The write strobe has two byte lanes.
- The read data is combinational from the halfword index.

Top module: `wdt_timer`

## Requirements
- R1: After reset, the timeout, configuration and status registers all read 0, and `irq`, `smi` and `sys_rst` are low.
- R2: The halfword index selects the register:
  - Index 0 is the timeout register.
  - Index 1 is configuration: prescale code [3:0], stage-one action [5:4], stage-two action [7:6], tick-off bit [8].
  - Index 2 is status: overflow [0], interrupt [1], system-management interrupt [2], reset [3].
  - Index 3 reads 0.
  - Strobe bit 0 writes data bits [7:0] and strobe bit 1 writes bits [15:8].
  - Reserved bits (configuration [15:9], status [15:4]) read 0 and ignore writes.
- R3: With timeout T and prescale code P, each stage ends on the max(T,1)·2^P-th counted tick after it began. A stage begins at a kick or when the previous stage ends. Stage two ends the same number of ticks after stage one. Stage two's end sets the overflow flag, and counting then returns to stage one.
- R4: Action codes are 00 (none), 01 (interrupt), 10 (system-management interrupt) and 11 (system reset). When a stage ends, its code sets the matching sticky status flag. The flag is visible on the clock after the ending tick.
- R5: `irq` and `smi` are high exactly while the interrupt and system-management interrupt flags are set. `sys_rst` is high for the single clock after a tick that ends a stage whose action is system reset.
- R6: A write to the timeout register, with either lane, is a kick. It reloads the count with the new value, clears the prescaler and restarts at stage one. A tick in the same cycle as a kick is not counted.
- R7: While the tick-off bit is 1, ticks are ignored and the count and prescaler hold their state. Clearing the bit resumes counting from where it stopped.
- R8: Writing a prescale code above 13 (14 or 15) keeps the previous code, while the action fields in the same write still update.
- R9: Writing status with data bit 0 set on lane 0 clears all four flags. Writing 0 there changes nothing. An action that fires in the same cycle as the clear leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| tick_en | input | 1 | One-cycle slow-tick enable |
| addr | input | 2 | Halfword register index |
| wr_en | input | 1 | Register write request |
| wr_strb | input | 2 | Byte-lane write strobes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request level |
| smi | output | 1 | System-management interrupt level |
| sys_rst | output | 1 | One-cycle system reset pulse |

## Verification
Read data depends combinationally on the register state, so any write is visible as soon as the next clock edge has passed. A stage that ends on a tick sampled at one edge shows its status flags, `irq` and `smi` just after that edge. The `sys_rst` pulse appears in that same cycle and is gone one clock later. The reference model advances at each rising edge using the inputs that were driven at the preceding falling edge. It is compared with the outputs 2 ns after the edge, so every expected value lands in the cycle the requirements give. The directed sequences step ticks one at a time and read status just before and just after each expiry boundary.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int WDT_REG_W  = 16;
    localparam int WDT_PRES_W = 4;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_IRQ  = 2'b01,
        ACT_SMI  = 2'b10,
        ACT_RST  = 2'b11
    } wdt_act_e;

    typedef struct packed {
        logic [WDT_REG_W-1:0]  timeout;
        logic [WDT_PRES_W-1:0] pres;
        wdt_act_e              act1;
        wdt_act_e              act2;
        logic                  tick_off;
        logic                  f_ovf;
        logic                  f_int;
        logic                  f_smi;
        logic                  f_rst;
        logic                  rst_pulse;
    } wdt_regs_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRES_W   = 4,
    parameter int PRES_MAX = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic [PRES_W-1:0] code,
    output logic              step
);
    localparam int PCNT_W = (PRES_MAX > 0) ? PRES_MAX : 1;

    logic [PCNT_W-1:0] pcnt_d, pcnt_q;
    logic [PCNT_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < PCNT_W; i++) begin
            mask[i] = (i < int'(code));
        end
        step   = tick && !clr && (pcnt_q >= mask);
        pcnt_d = pcnt_q;
        if (clr) begin
            pcnt_d = '0;
        end else if (tick) begin
            pcnt_d = step ? '0 : pcnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  logic [CNT_W-1:0] reload_val,
    output logic             exp1,
    output logic             exp2,
    output logic [CNT_W-1:0] cnt,
    output logic             stage2
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             stage2;
    } cd_state_t;

    cd_state_t st_d, st_q;
    logic      expire;

    always_comb begin
        st_d   = st_q;
        expire = step && !load && (st_q.cnt <= CNT_W'(1));
        if (load) begin
            st_d.cnt    = load_val;
            st_d.stage2 = 1'b0;
        end else if (step) begin
            if (expire) begin
                st_d.cnt    = reload_val;
                st_d.stage2 = !st_q.stage2;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        exp1 = expire && !st_q.stage2;
        exp2 = expire &&  st_q.stage2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt    = st_q.cnt;
    assign stage2 = st_q.stage2;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int PRES_MAX = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic [1:0]  addr,
    input  logic        wr_en,
    input  logic [1:0]  wr_strb,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        irq,
    output logic        smi,
    output logic        sys_rst
);
    localparam logic [1:0] IDX_TO  = 2'd0;
    localparam logic [1:0] IDX_CFG = 2'd1;
    localparam logic [1:0] IDX_STS = 2'd2;

    wdt_regs_t regs_d, regs_q;

    logic                 kick, tick_live, step, exp1, exp2, stage2;
    logic                 sts_clr;
    logic [WDT_REG_W-1:0] cnt;
    wdt_act_e             fired;
    logic                 unused_bits;

    assign kick      = wr_en && (addr == IDX_TO) && (|wr_strb);
    assign tick_live = tick_en && !regs_q.tick_off;
    assign sts_clr   = wr_en && (addr == IDX_STS) && wr_strb[0] && wdata[0];
    assign unused_bits = ^{wdata[15:9], stage2};

    wdt_prescaler #(.PRES_W(WDT_PRES_W), .PRES_MAX(PRES_MAX)) u_pres (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (kick),
        .tick (tick_live),
        .code (regs_q.pres),
        .step (step)
    );

    wdt_countdown #(.CNT_W(WDT_REG_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (kick),
        .load_val  (regs_d.timeout),
        .step      (step),
        .reload_val(regs_q.timeout),
        .exp1      (exp1),
        .exp2      (exp2),
        .cnt       (cnt),
        .stage2    (stage2)
    );

    always_comb begin
        regs_d = regs_q;
        fired  = exp1 ? regs_q.act1 : (exp2 ? regs_q.act2 : ACT_NONE);

        if (wr_en && addr == IDX_TO) begin
            if (wr_strb[0]) regs_d.timeout[7:0]  = wdata[7:0];
            if (wr_strb[1]) regs_d.timeout[15:8] = wdata[15:8];
        end
        if (wr_en && addr == IDX_CFG) begin
            if (wr_strb[0]) begin
                if (int'(wdata[3:0]) <= PRES_MAX) regs_d.pres = wdata[3:0];
                regs_d.act1 = wdt_act_e'(wdata[5:4]);
                regs_d.act2 = wdt_act_e'(wdata[7:6]);
            end
            if (wr_strb[1]) regs_d.tick_off = wdata[8];
        end

        if (sts_clr) begin
            regs_d.f_ovf = 1'b0;
            regs_d.f_int = 1'b0;
            regs_d.f_smi = 1'b0;
            regs_d.f_rst = 1'b0;
        end
        if (exp2)             regs_d.f_ovf = 1'b1;
        if (fired == ACT_IRQ) regs_d.f_int = 1'b1;
        if (fired == ACT_SMI) regs_d.f_smi = 1'b1;
        if (fired == ACT_RST) regs_d.f_rst = 1'b1;
        regs_d.rst_pulse = (fired == ACT_RST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (addr)
            IDX_TO:  rdata = regs_q.timeout;
            IDX_CFG: rdata = {7'd0, regs_q.tick_off, regs_q.act2, regs_q.act1, regs_q.pres};
            IDX_STS: rdata = {12'd0, regs_q.f_rst, regs_q.f_smi, regs_q.f_int, regs_q.f_ovf};
            default: rdata = '0;
        endcase
    end

    assign irq     = regs_q.f_int;
    assign smi     = regs_q.f_smi;
    assign sys_rst = regs_q.rst_pulse;
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
    parameter int PRES_MAX = 13
) (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  addr,
    input logic        wr_en,
    input logic [1:0]  wr_strb,
    input logic [15:0] wdata,
    input logic        irq,
    input logic        smi,
    input logic        sys_rst,
    input logic [3:0]  pres,
    input logic        tick_off,
    input logic        f_rst,
    input logic [15:0] cnt,
    input logic [15:0] timeout
);
    logic clr_wr, cfg_lo_wr, kick_wr;
    assign clr_wr    = wr_en && addr == 2'd2 && wr_strb[0] && wdata[0];
    assign cfg_lo_wr = wr_en && addr == 2'd1 && wr_strb[0];
    assign kick_wr   = wr_en && addr == 2'd0 && (|wr_strb);

    assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq);

    assert_smi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smi && !clr_wr) |=> smi);

    assert_rst_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> f_rst);

    assert_kick_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        kick_wr |=> (cnt == timeout));

    assert_tick_off_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_off && !kick_wr) |=> $stable(cnt));

    assert_pres_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lo_wr && int'(wdata[3:0]) > PRES_MAX) |=> $stable(pres));

    assert_pres_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pres) <= PRES_MAX);
endmodule

bind wdt_timer wdt_timer_chk #(.PRES_MAX(PRES_MAX)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_strb (wr_strb),
    .wdata   (wdata),
    .irq     (irq),
    .smi     (smi),
    .sys_rst (sys_rst),
    .pres    (regs_q.pres),
    .tick_off(regs_q.tick_off),
    .f_rst   (regs_q.f_rst),
    .cnt     (cnt),
    .timeout (regs_q.timeout)
);

// File: tb/wdt_timer_test.sv
`timescale 1ns/1ps
module wdt_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_strb = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        irq, smi, sys_rst;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit tick_on = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdt_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
        .wr_en(wr_en), .wr_strb(wr_strb), .wdata(wdata), .rdata(rdata),
        .irq(irq), .smi(smi), .sys_rst(sys_rst)
    );

    // behavioural reference model
    int m_to, m_pres, m_a1, m_a2, m_off;
    int m_int, m_smi, m_rst, m_ovf, m_pulse;
    int m_stage, m_ticks;

    always @(posedge clk) begin
        int act, per;
        bit kick;
        if (!rst_n) begin
            m_to = 0; m_pres = 0; m_a1 = 0; m_a2 = 0; m_off = 0;
            m_int = 0; m_smi = 0; m_rst = 0; m_ovf = 0; m_pulse = 0;
            m_stage = 1; m_ticks = 0;
        end else begin
            act  = 0;
            kick = wr_en && addr == 2'd0 && wr_strb != 2'd0;
            per  = ((m_to == 0) ? 1 : m_to) << m_pres;
            if (kick) begin
                m_ticks = 0; m_stage = 1;
            end else if (tick_en && m_off == 0) begin
                m_ticks++;
                if (m_ticks == per) begin
                    m_ticks = 0;
                    act = (m_stage == 1) ? m_a1 : m_a2;
                    if (m_stage == 2) act += 4;
                    m_stage = (m_stage == 1) ? 2 : 1;
                end
            end
            if (wr_en && addr == 2'd0) begin
                if (wr_strb[0]) m_to = (m_to & 16'hFF00) | int'(wdata[7:0]);
                if (wr_strb[1]) m_to = (m_to & 16'h00FF) | (int'(wdata[15:8]) << 8);
            end
            if (wr_en && addr == 2'd1) begin
                if (wr_strb[0]) begin
                    if (wdata[3:0] <= 4'd13) m_pres = int'(wdata[3:0]);
                    m_a1 = int'(wdata[5:4]);
                    m_a2 = int'(wdata[7:6]);
                end
                if (wr_strb[1]) m_off = int'(wdata[8]);
            end
            if (wr_en && addr == 2'd2 && wr_strb[0] && wdata[0]) begin
                m_int = 0; m_smi = 0; m_rst = 0; m_ovf = 0;
            end
            if (act >= 4) m_ovf = 1;
            if ((act & 3) == 1) m_int = 1;
            if ((act & 3) == 2) m_smi = 1;
            m_pulse = ((act & 3) == 3) ? 1 : 0;
            if (m_pulse == 1) m_rst = 1;
        end
    end

    function automatic logic [15:0] model_rd(input logic [1:0] a);
        case (a)
            2'd0: return 16'(m_to);
            2'd1: return 16'((m_off << 8) | (m_a2 << 6) | (m_a1 << 4) | m_pres);
            2'd2: return 16'((m_rst << 3) | (m_smi << 2) | (m_int << 1) | m_ovf);
            default: return 16'd0;
        endcase
    endfunction

    // per-cycle comparison, 2 ns after the active edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            checks++;
            if (irq !== (m_int != 0) || smi !== (m_smi != 0) || sys_rst !== (m_pulse != 0)) begin
                errors++;
                $display("FAIL R5 cycle %0d: irq/smi/rst got %b%b%b expected %0d%0d%0d",
                         cyc, irq, smi, sys_rst, m_int, m_smi, m_pulse);
            end
            checks++;
            if (rdata !== model_rd(addr)) begin
                errors++;
                $display("FAIL R3 cycle %0d: rdata[%0d] got %h expected %h",
                         cyc, addr, rdata, model_rd(addr));
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (tick_on) tick_en <= (cyc % 3 == 0);
    end

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_strb = s; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
        addr = a;
        #1;
        chk(rdata, exp, tag);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, 16'h0000, "R1 timeout");
        rd(2'd1, 16'h0000, "R1 config");
        rd(2'd2, 16'h0000, "R1 status");
        chk({13'd0, irq, smi, sys_rst}, 16'h0, "R1 outputs");

        // R2 reserved bits: act2=RST act1=IRQ pres=1
        wr(2'd1, 2'b11, 16'hFED1);
        rd(2'd1, 16'h00D1, "R2 config reserved");
        wr(2'd0, 2'b11, 16'd3);
        tick_on = 1'b1;
        repeat (120) @(negedge clk);
        tick_on = 1'b0; tick_en = 1'b0;
        rd(2'd2, 16'h000B, "R4 irq+rst+ovf flags");

        // R3 exact expiry: act1=IRQ act2=SMI pres=1, T=2 -> 4 ticks/stage
        wr(2'd1, 2'b11, 16'h0091);
        wr(2'd2, 2'b01, 16'h0001);
        wr(2'd0, 2'b11, 16'd2);
        ticks(3);
        rd(2'd2, 16'h0000, "R3 before stage1 end");
        ticks(1);
        rd(2'd2, 16'h0002, "R3 stage1 end irq");
        ticks(3);
        rd(2'd2, 16'h0002, "R3 before stage2 end");
        ticks(1);
        rd(2'd2, 16'h0007, "R3 stage2 end smi+ovf");
        chk({15'd0, smi}, 16'h1, "R5 smi level");

        // R9 clear semantics
        wr(2'd2, 2'b01, 16'h0000);
        rd(2'd2, 16'h0007, "R9 write 0 no effect");
        wr(2'd2, 2'b01, 16'h0001);
        rd(2'd2, 16'h0000, "R9 clear all");
        chk({15'd0, irq}, 16'h0, "R9 irq dropped");

        // R6 kick restarts
        wr(2'd0, 2'b11, 16'd2);
        ticks(3);
        wr(2'd0, 2'b01, 16'd2);
        ticks(3);
        rd(2'd2, 16'h0000, "R6 kick restarted");
        ticks(1);
        rd(2'd2, 16'h0002, "R6 expiry after kick");

        // R7 tick off
        wr(2'd2, 2'b01, 16'h0001);
        wr(2'd0, 2'b11, 16'd2);
        ticks(2);
        wr(2'd1, 2'b10, 16'h0100);
        ticks(10);
        rd(2'd2, 16'h0000, "R7 halted");
        wr(2'd1, 2'b10, 16'h0000);
        ticks(1);
        rd(2'd2, 16'h0000, "R7 resumed partial");
        ticks(1);
        rd(2'd2, 16'h0002, "R7 resumed expiry");

        // R8 reserved prescale code
        wr(2'd1, 2'b01, 16'h009E);
        rd(2'd1, 16'h0091, "R8 prescale kept");
        wr(2'd2, 2'b01, 16'h0001);
        wr(2'd0, 2'b11, 16'd1);
        ticks(1);
        rd(2'd2, 16'h0000, "R8 timing one tick");
        ticks(1);
        rd(2'd2, 16'h0002, "R8 timing two ticks");

        // R2 byte lanes
        wr(2'd0, 2'b10, 16'hAB00);
        rd(2'd0, 16'hAB01, "R2 timeout high lane");
        wr(2'd0, 2'b01, 16'h0034);
        rd(2'd0, 16'hAB34, "R2 timeout low lane");
        wr(2'd1, 2'b10, 16'h01FF);
        rd(2'd1, 16'h0191, "R2 config high lane");
        rd(2'd3, 16'h0000, "R2 index 3");

        // R3 timeout zero acts as one, pres 0
        wr(2'd1, 2'b11, 16'h0090);
        wr(2'd2, 2'b01, 16'h0001);
        wr(2'd0, 2'b11, 16'd0);
        ticks(1);
        rd(2'd2, 16'h0002, "R3 T0 stage1");
        ticks(1);
        rd(2'd2, 16'h0007, "R3 T0 stage2");

        // R5 reset pulse, R4 reset flag
        wr(2'd1, 2'b11, 16'h0030);
        wr(2'd2, 2'b01, 16'h0001);
        wr(2'd0, 2'b11, 16'd1);
        ticks(1);
        chk({15'd0, sys_rst}, 16'h1, "R5 reset pulse high");
        rd(2'd2, 16'h0008, "R4 reset flag");
        @(negedge clk);
        chk({15'd0, sys_rst}, 16'h0, "R5 reset pulse one cycle");

        // free-running mixed run
        wr(2'd1, 2'b11, 16'h00E0);
        wr(2'd0, 2'b11, 16'd2);
        tick_on = 1'b1;
        repeat (400) @(negedge clk);
        tick_on = 1'b0; tick_en = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule